// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block walks the tag state of a set-associative write-back cache and carries out one maintenance command at a time. The commands are: clean or invalidate the line that holds a virtual address, clean or invalidate a line named by a set/way word, invalidate the whole cache, flush a line picked by a physical address, and scan for the first dirty line. The tag array sits outside the block. It is read combinationally at the set and way the block drives, and it is written through two strobes. The first strobe clears only the dirty halves. The second clears the whole entry.

When a chosen line is valid and has either half dirty, the block raises a write-back request to an external engine. It holds the request until the engine acknowledges, and only then updates the tag. A command begins with a one-cycle `start` and ends with a one-cycle `done`. After a scan, the found flag and the line location stay on the outputs until the next scan begins.

Command codes on `cmd`: 0 clean by address, 1 invalidate by address, 2 clean by set/way, 3 invalidate by set/way, 4 invalidate all, 5 flush by physical address, 6 dirty scan. Code 7 ends with `done` and has no other effect. The set count and the way count must be powers of two, and the way count must be at least two. With the defaults (32-byte lines, 4 sets, 4 ways) the line offset is bits 4:0, the set index is bits 6:5 and the address tag is bits 31:7.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset `busy`, `done`, `wb_req`, `tag_clean_we` and `tag_inval_we` are all low, and none of the last three is ever high while `busy` is low.
- R2: A set/way command takes the way from operand bits [31:31-log2(ways)+1] and the set from the index field (bits 6:5 by default); every other operand bit is ignored.
- R3: A clean command writes back the chosen line when it is valid and dirty, reporting its two dirty bits on `wb_dirty`. It then clears only the dirty bits, so the line stays valid with the same tag.
- R4: An invalidate command (by address or set/way) performs the same conditional write-back and then clears the whole entry, so the line becomes invalid.
- R5: A line that is clean or invalid causes no write-back request.
- R6: An address command whose lookup misses in every way of the indexed set issues no write-back and no tag write.
- R7: An address lookup compares operand bits 31:7 with the stored tag of valid ways only, so an invalid way holding a matching tag is skipped.
- R8: Invalidate-all visits every line in ascending order (set major, way minor), writes back each valid dirty line, and leaves every line invalid.
- R9: A physical-address flush forms line = address / line bytes, way = line mod ways, set = (line / ways) mod sets. It writes back that line if it is dirty and clears its entry.
- R10: The dirty scan checks lines in ascending order (set major, way minor) and reports the first line with either dirty bit set, whatever its valid bit. If no line is dirty it reports `found` low. The scan issues no write-back.
- R11: `done` is high for exactly one cycle per command, and a `start` seen while busy is ignored.
- R12: `wb_req` and its set and way stay steady until `wb_ack`, and no tag write occurs while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| cmd | input | 3 | Command code |
| operand | input | 32 | Address or set/way word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| found | output | 1 | Last scan found a dirty line |
| found_set | output | SETB | Set of the line found |
| found_way | output | WAYB | Way of the line found |
| tag_set | output | SETB | Tag array read/write set |
| tag_way | output | WAYB | Tag array read/write way |
| tag_rd_valid | input | 1 | Valid bit at tag_set/tag_way |
| tag_rd_tag | input | TAGW | Stored address tag |
| tag_rd_dirty | input | 2 | Dirty bits for the two halves |
| tag_clean_we | output | 1 | Clear the dirty bits at tag_set/tag_way |
| tag_inval_we | output | 1 | Clear the whole entry at tag_set/tag_way |
| wb_req | output | 1 | Write-back request |
| wb_set | output | SETB | Set of the line to write back |
| wb_way | output | WAYB | Way of the line to write back |
| wb_dirty | output | 2 | Halves to write back |
| wb_ack | input | 1 | Write-back finished |

## Verification
The bench sweeps every set and way with every dirty pattern and plants junk in the operand bits that should be ignored. A wrong slice of the way or set field would then write back or clear the wrong entry. Address lookups put a matching tag in an invalid way ahead of the real hit. A design that ignored the valid bit would clean the wrong line, and one that did not stop at a miss would touch state. The physical-address flush is swept over 32 line numbers, which exposes a swapped way/set split. Invalidate-all and the scan are checked for ascending order, and the scan for dirty lines that are not valid. A start pulse is injected mid-command: a design that accepted it would give a second `done` or leave lines valid.

// File: rtl/cache_maint_seq.sv
module cache_maint_seq #(
  parameter int LINE_BYTES = 32,
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int OFFB = $clog2(LINE_BYTES),
  localparam int SETB = $clog2(SETS),
  localparam int WAYB = $clog2(WAYS),
  localparam int TAGW = 32 - OFFB - SETB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      cmd,
  input  logic [31:0]     operand,
  output logic            busy,
  output logic            done,
  output logic            found,
  output logic [SETB-1:0] found_set,
  output logic [WAYB-1:0] found_way,
  output logic [SETB-1:0] tag_set,
  output logic [WAYB-1:0] tag_way,
  input  logic            tag_rd_valid,
  input  logic [TAGW-1:0] tag_rd_tag,
  input  logic [1:0]      tag_rd_dirty,
  output logic            tag_clean_we,
  output logic            tag_inval_we,
  output logic            wb_req,
  output logic [SETB-1:0] wb_set,
  output logic [WAYB-1:0] wb_way,
  output logic [1:0]      wb_dirty,
  input  logic            wb_ack
);
  localparam int IDXW = SETB + WAYB;
  localparam logic [2:0] C_CLN_VA = 3'd0, C_INV_VA = 3'd1, C_CLN_SW = 3'd2,
                         C_INV_SW = 3'd3, C_INV_ALL = 3'd4, C_FLUSH_PA = 3'd5,
                         C_SCAN = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_SRCH, S_CHK, S_WB, S_UPD, S_SCAN, S_FIN} st_t;

  st_t             st;
  logic [2:0]      cmd_q;
  logic [TAGW-1:0] vtag_q;
  logic [SETB-1:0] set_q;
  logic [WAYB-1:0] way_q;

  wire last_way  = way_q == WAYB'(WAYS - 1);
  wire last_line = last_way && set_q == SETB'(SETS - 1);
  wire hit       = tag_rd_valid && tag_rd_tag == vtag_q;
  wire dirty     = tag_rd_valid && |tag_rd_dirty;
  wire is_inv    = cmd_q == C_INV_VA || cmd_q == C_INV_SW ||
                   cmd_q == C_INV_ALL || cmd_q == C_FLUSH_PA;

  assign busy         = st != S_IDLE;
  assign done         = st == S_FIN;
  assign tag_set      = set_q;
  assign tag_way      = way_q;
  assign wb_req       = st == S_WB;
  assign wb_set       = set_q;
  assign wb_way       = way_q;
  assign wb_dirty     = tag_rd_dirty;
  assign tag_clean_we = st == S_UPD && !is_inv;
  assign tag_inval_we = st == S_UPD && is_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_q     <= '0;
      vtag_q    <= '0;
      set_q     <= '0;
      way_q     <= '0;
      found     <= 1'b0;
      found_set <= '0;
      found_way <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cmd_q  <= cmd;
          vtag_q <= operand[31 -: TAGW];
          set_q  <= operand[OFFB +: SETB];
          way_q  <= '0;
          case (cmd)
            C_CLN_VA, C_INV_VA: st <= S_SRCH;
            C_CLN_SW, C_INV_SW: begin
              way_q <= operand[31 -: WAYB];
              st    <= S_CHK;
            end
            C_INV_ALL: begin
              set_q <= '0;
              st    <= S_CHK;
            end
            C_FLUSH_PA: begin
              way_q <= operand[OFFB +: WAYB];
              set_q <= operand[OFFB + WAYB +: SETB];
              st    <= S_CHK;
            end
            C_SCAN: begin
              set_q <= '0;
              found <= 1'b0;
              st    <= S_SCAN;
            end
            default: st <= S_FIN;
          endcase
        end
        S_SRCH: begin
          if (hit) st <= S_CHK;
          else if (last_way) st <= S_FIN;
          else way_q <= way_q + WAYB'(1);
        end
        S_CHK: st <= dirty ? S_WB : S_UPD;
        S_WB:  if (wb_ack) st <= S_UPD;
        S_UPD: begin
          if (cmd_q == C_INV_ALL && !last_line) begin
            {set_q, way_q} <= {set_q, way_q} + IDXW'(1);
            st <= S_CHK;
          end else st <= S_FIN;
        end
        S_SCAN: begin
          if (|tag_rd_dirty) begin
            found     <= 1'b1;
            found_set <= set_q;
            found_way <= way_q;
            st        <= S_FIN;
          end else if (last_line) st <= S_FIN;
          else {set_q, way_q} <= {set_q, way_q} + IDXW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wb_req && !tag_clean_we && !tag_inval_we);

  assert_wb_only_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> tag_rd_valid && tag_rd_dirty != 2'b00);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_wb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> wb_req && $stable(wb_set) && $stable(wb_way));

  assert_no_write_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !tag_clean_we && !tag_inval_we);
endmodule

// File: tb/cache_maint_seq_tb_top.sv
`timescale 1ns/100ps
module cache_maint_seq_tb_top;
  logic clk = 0, rst_n = 0, start = 0, wb_ack = 0;
  logic [2:0] cmd = 0;
  logic [31:0] operand = 0;
  logic busy, done, found, tag_clean_we, tag_inval_we, wb_req;
  logic [1:0] found_set, found_way, tag_set, tag_way, wb_set, wb_way, wb_dirty;
  logic [1:0] tag_rd_dirty;
  logic tag_rd_valid;
  logic [24:0] tag_rd_tag;

  logic mv[16];
  logic [24:0] mt[16];
  logic [1:0] md[16];
  int wbn = 0, nchk = 0, nerr = 0, ndone = 0;
  int wbidx[256];
  int wbd[256];

  always #2.5 clk = ~clk;
  always @(posedge clk) wb_ack <= rst_n && wb_req && !wb_ack;

  assign tag_rd_valid = mv[{tag_set, tag_way}];
  assign tag_rd_tag   = mt[{tag_set, tag_way}];
  assign tag_rd_dirty = md[{tag_set, tag_way}];

  cache_maint_seq dut_i (.clk, .rst_n, .start, .cmd, .operand, .busy, .done, .found,
    .found_set, .found_way, .tag_set, .tag_way, .tag_rd_valid, .tag_rd_tag,
    .tag_rd_dirty, .tag_clean_we, .tag_inval_we, .wb_req, .wb_set, .wb_way,
    .wb_dirty, .wb_ack);

  task automatic chk(string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) begin mv[i] = 0; mt[i] = 0; md[i] = 0; end
  endtask

  task automatic run(input logic [2:0] c, input logic [31:0] o, input bit spur);
    int cyc = 0;
    ndone = 0;
    start = 1; cmd = c; operand = o;
    @(negedge clk);
    start = 0;
    while (cyc < 400) begin
      if (spur && cyc == 2) begin start = 1; cmd = 3'd6; end
      else start = 0;
      if (wb_req && wb_ack) begin
        wbidx[wbn] = {wb_set, wb_way}; wbd[wbn] = wb_dirty; wbn++;
      end
      if (tag_clean_we) md[{tag_set, tag_way}] = 0;
      if (tag_inval_we) begin
        mv[{tag_set, tag_way}] = 0; mt[{tag_set, tag_way}] = 0; md[{tag_set, tag_way}] = 0;
      end
      if (done) ndone++;
      if (!busy && cyc > 0 && !spur) break;
      if (!busy && spur && cyc > 6) break;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    if (cyc >= 400) chk("watchdog R11", 0, 1);
  endtask

  function automatic int nvalid();
    int n = 0;
    for (int i = 0; i < 16; i++) n += mv[i];
    return n;
  endfunction

  initial begin
    int b, idx;
    clear_all();
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 wb_req", wb_req, 0);
    chk("R1 tag writes", tag_clean_we | tag_inval_we, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R5: clean by set/way, swept over every line and dirty pattern
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) for (int d = 0; d < 4; d++) begin
      clear_all();
      idx = s * 4 + w;
      mv[idx] = 1; mt[idx] = 25'(s * 7 + w + 1); md[idx] = 2'(d);
      b = wbn;
      run(3'd2, (32'(w) << 30) | (32'(s) << 5) | 32'h0000_3e13, 0);
      chk("R5 R3 wb count", wbn - b, d != 0);
      if (d != 0) begin
        chk("R2 wb line", wbidx[b], idx);
        chk("R3 wb dirty", wbd[b], d);
      end
      chk("R3 stays valid", mv[idx], 1);
      chk("R3 tag kept", int'(mt[idx]), s * 7 + w + 1);
      chk("R3 dirty cleared", md[idx], 0);
      chk("R1 single done", ndone, 1);
    end

    // R4: invalidate by set/way, dirty and clean lines
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) begin
      clear_all();
      for (int i = 0; i < 16; i++) begin mv[i] = 1; mt[i] = 25'(i + 3); end
      idx = s * 4 + w;
      md[idx] = 2'(((s + w) % 2) * 3);
      b = wbn;
      run(3'd3, (32'(w) << 30) | (32'(s) << 5) | 32'h0100_0400, 0);
      chk("R4 R2 wb count", wbn - b, (s + w) % 2);
      if ((s + w) % 2 == 1) chk("R4 wb line", wbidx[b], idx);
      chk("R4 invalid", mv[idx], 0);
      chk("R2 others untouched", nvalid(), 15);
    end

    // R7 R6: address lookup
    clear_all();
    mv[8] = 1; mt[8] = 25'd100;
    mv[9] = 0; mt[9] = 25'd555; md[9] = 2'd3;
    mv[10] = 1; mt[10] = 25'd200; md[10] = 2'd1;
    mv[11] = 1; mt[11] = 25'd555; md[11] = 2'd2;
    b = wbn;
    run(3'd0, (32'd555 << 7) | (32'd2 << 5) | 32'd9, 0);
    chk("R7 wb count", wbn - b, 1);
    chk("R7 wb line skips invalid way", wbidx[b], 11);
    chk("R7 wb dirty", wbd[b], 2);
    chk("R7 clean keeps valid", mv[11], 1);
    chk("R7 dirty cleared", md[11], 0);
    chk("R7 invalid way untouched", md[9], 3);
    b = wbn;
    run(3'd1, (32'd777 << 7) | (32'd2 << 5), 0);
    chk("R6 miss wb", wbn - b, 0);
    chk("R6 miss valid", nvalid(), 3);
    chk("R6 miss dirty", md[10], 1);
    run(3'd1, (32'd100 << 7) | (32'd1 << 5), 0);
    chk("R6 other set miss", nvalid(), 3);
    chk("R6 wb", wbn - b, 0);
    chk("R1 done on miss", ndone, 1);
    run(3'd1, (32'd200 << 7) | (32'd2 << 5) | 32'd31, 0);
    chk("R4 va wb", wbn - b, 1);
    chk("R4 va wb line", wbidx[b], 10);
    chk("R4 va invalid", mv[10], 0);

    // R9: physical-address flush
    for (int k = 0; k < 2; k++) for (int l = 0; l < 16; l++) begin
      clear_all();
      for (int i = 0; i < 16; i++) begin mv[i] = 1; mt[i] = 25'(i); md[i] = 2'd3; end
      idx = ((l / 4) % 4) * 4 + (l % 4);
      b = wbn;
      run(3'd5, (32'(l + 16 * k + 48 * k) << 5) | 32'd7, 0);
      chk("R9 wb count", wbn - b, 1);
      chk("R9 wb line", wbidx[b], idx);
      chk("R9 line invalid", mv[idx], 0);
      chk("R9 others valid", nvalid(), 15);
    end

    // R8: invalidate all
    begin
      int exp[16];
      int ne = 0;
      clear_all();
      for (int i = 0; i < 16; i++) begin
        mv[i] = (i % 3) != 0; mt[i] = 25'(i + 1); md[i] = 2'(i % 4);
        if (mv[i] && md[i] != 0) begin exp[ne] = i; ne++; end
      end
      b = wbn;
      run(3'd4, 32'hdead_beef, 0);
      chk("R8 wb count", wbn - b, ne);
      for (int j = 0; j < ne; j++) chk("R8 wb order", wbidx[b + j], exp[j]);
      chk("R8 all invalid", nvalid(), 0);
    end

    // R10: dirty scan
    clear_all();
    b = wbn;
    run(3'd6, 0, 0);
    chk("R10 none found", found, 0);
    for (int i = 0; i < 16; i++) begin
      clear_all();
      md[i] = 2'(1 + i % 2); mv[i] = i % 2;
      md[(i + 5) % 16 > i ? (i + 5) % 16 : i] = 2'd2;
      run(3'd6, 0, 0);
      chk("R10 found", found, 1);
      chk("R10 first line", {found_set, found_way}, i);
    end
    clear_all();
    md[12] = 1; md[11] = 3; md[9] = 2;
    run(3'd6, 0, 0);
    chk("R10 ascending order", {found_set, found_way}, 9);
    chk("R10 no wb", wbn - b, 0);

    // R11: start while busy ignored
    clear_all();
    for (int i = 0; i < 16; i++) begin mv[i] = 1; md[i] = 2'(i % 2); end
    b = wbn;
    run(3'd4, 0, 1);
    chk("R11 single done", ndone, 1);
    chk("R11 all invalid", nvalid(), 0);
    chk("R11 wb count", wbn - b, 8);
    chk("R11 scan result kept", {found_set, found_way}, 9);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule